// File: doc/BRIEF.md
# Byte-Serial Ones-Complement Checksum Accumulator

This block keeps a 16-bit ones-complement running sum, the arithmetic behind the Internet checksum. A processor reaches it through one byte-wide data register. It writes each 16-bit operand as two bytes, the high byte first. The block then adds the operand into the sum and feeds the carry out of the top bit back into the bottom bit.

To read the sum, the processor strobes the read port twice and gets the high byte and then the low byte. After the second read the sum returns to zero, so the next checksum starts clean. Software inverts the result and handles framing. Neither is done here.

Top module: `oc_csum_top`

## Requirements
- R1: After reset the sum is 0000h and both byte sequencers expect the high byte next, so the first two reads return 00h and 00h.
- R2: Two write strobes form one operand. The byte on the first strobe is bits 15:8 and the byte on the second strobe is bits 7:0.
- R3: An operand is added in the clock cycle after its second write strobe. Operand pairs may be written on consecutive cycles with no idle cycle between pairs, and each pair is added.
- R4: The add is ones-complement. The carry out of bit 15 is added into bit 0, so FFFFh+0001h gives 0001h, 8000h+8000h gives 0001h and FFFFh+FFFFh gives FFFFh.
- R5: Two read strobes return the sum, bits 15:8 on the first strobe and bits 7:0 on the second. `rd_data` is valid combinationally in the cycle `rd_en` is high.
- R6: On the clock edge that ends the second read, the sum is cleared to 0000h.
- R7: The low byte is captured at the first read. The second read returns that captured byte even if the sum changes between the two reads.
- R8: A lone first write byte does not change the sum. Reset discards a half-written operand.
- R9: Two reads are always enough to bring the sum to zero, so the next operand written afterwards is the whole new sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Write strobe for one operand byte |
| wr_data | input | 8 | Operand byte |
| rd_en | input | 1 | Read strobe for one sum byte |
| rd_data | output | 8 | Sum byte selected by the read sequencer |

## Verification
The assertions assume that `wr_en` and `rd_en` are never high in the same cycle. They also assume that the second read never falls in the same cycle as an add, because the clear would hide that add. The stimulus keeps to both rules: every read stands alone in its cycle, and at least one idle cycle separates the last write pair from any read. The one test that writes between the two reads also puts an idle cycle before the second read.

// File: rtl/oc_csum_pkg.sv
package oc_csum_pkg;
    typedef enum logic {
        PH_HI = 1'b0,
        PH_LO = 1'b1
    } phase_e;
endpackage

// File: rtl/oc_endaround_add.sv
module oc_endaround_add #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    localparam int WX = W + 1;

    logic [WX-1:0] raw;
    logic [W-1:0]  carry_in;

    always_comb begin
        raw      = {1'b0, a} + {1'b0, b};
        carry_in = '0;
        carry_in[0] = raw[W];
        y        = raw[W-1:0] + carry_in;
    end
endmodule

// File: rtl/oc_wr_assembler.sv
module oc_wr_assembler
    import oc_csum_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [BYTE_W-1:0]   wr_data,
    output logic                op_valid,
    output logic [2*BYTE_W-1:0] op_word
);
    localparam int WORD_W = 2 * BYTE_W;

    typedef struct packed {
        phase_e              phase;
        logic [BYTE_W-1:0]   hi;
        logic                pend;
        logic [WORD_W-1:0]   op;
    } wr_state_t;

    wr_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.pend = 1'b0;
        if (wr_en) begin
            if (st_q.phase == PH_HI) begin
                st_d.hi    = wr_data;
                st_d.phase = PH_LO;
            end else begin
                st_d.op    = {st_q.hi, wr_data};
                st_d.pend  = 1'b1;
                st_d.phase = PH_HI;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_HI, hi: '0, pend: 1'b0, op: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign op_valid = st_q.pend;
    assign op_word  = st_q.op;

    // R3: an add lasts one cycle, and pairs cannot complete on consecutive edges
    a_r3_pend_single: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pend |=> !st_q.pend);
    // R2: every write strobe advances the byte sequencer
    a_r2_phase_flip: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> st_q.phase != $past(st_q.phase));
    // R8: with no write strobe, the sequencer holds
    a_r8_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(st_q.phase));
endmodule

// File: rtl/oc_rd_unloader.sv
module oc_rd_unloader
    import oc_csum_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_en,
    input  logic [2*BYTE_W-1:0] sum,
    output logic [BYTE_W-1:0]   rd_data,
    output logic                clr
);
    typedef struct packed {
        phase_e            phase;
        logic [BYTE_W-1:0] lo_snap;
    } rd_state_t;

    rd_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        clr  = 1'b0;
        if (rd_en) begin
            if (st_q.phase == PH_HI) begin
                st_d.lo_snap = sum[BYTE_W-1:0];
                st_d.phase   = PH_LO;
            end else begin
                clr        = 1'b1;
                st_d.phase = PH_HI;
            end
        end
        rd_data = (st_q.phase == PH_HI) ? sum[2*BYTE_W-1:BYTE_W] : st_q.lo_snap;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_HI, lo_snap: '0};
        end else begin
            st_q <= st_d;
        end
    end

    // R7: the captured low byte holds while it waits for the second read
    a_r7_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_LO) |=> $stable(st_q.lo_snap));
    // R5: every read strobe advances the read sequencer
    a_r5_rd_flip: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> st_q.phase != $past(st_q.phase));
endmodule

// File: rtl/oc_csum_top.sv
module oc_csum_top #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [BYTE_W-1:0] rd_data
);
    localparam int WORD_W = 2 * BYTE_W;

    typedef struct packed {
        logic [WORD_W-1:0] acc;
    } acc_state_t;

    acc_state_t        st_d, st_q;
    logic              op_valid;
    logic [WORD_W-1:0] op_word;
    logic [WORD_W-1:0] sum_next;
    logic              clr;

    oc_wr_assembler #(.BYTE_W(BYTE_W)) wr_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .op_valid(op_valid), .op_word(op_word)
    );

    oc_endaround_add #(.W(WORD_W)) add_i (
        .a(st_q.acc), .b(op_word), .y(sum_next)
    );

    oc_rd_unloader #(.BYTE_W(BYTE_W)) rd_i (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .sum(st_q.acc),
        .rd_data(rd_data), .clr(clr)
    );

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.acc = '0;
        end else if (op_valid) begin
            st_d.acc = sum_next;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{acc: '0};
        end else begin
            st_q <= st_d;
        end
    end

    // R6: the second read leaves a zero sum
    a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> st_q.acc == '0);
    // R4: a ones-complement sum of inputs that are not all zero never becomes zero
    a_r4_no_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !clr && (st_q.acc != '0 || op_word != '0)) |=> st_q.acc != '0);
    // R3: the sum changes only on an add or a clear
    a_r3_only_on_add: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid && !clr) |=> $stable(st_q.acc));
endmodule

// File: tb/oc_csum_tb.sv
module oc_csum_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;

    int n_checks = 0;
    int n_fail   = 0;
    logic [15:0] model = '0;
    logic [7:0]  exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    oc_csum_top dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data)
    );

    function automatic logic [15:0] oc_add(input logic [15:0] a, input logic [15:0] b);
        logic [16:0] t;
        t = {1'b0, a} + {1'b0, b};
        t = {1'b0, t[15:0]} + {16'd0, t[16]};
        return t[15:0];
    endfunction

    task automatic report();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // monitor: compares each read byte against the scoreboard
    always @(negedge clk) begin
        #2;
        if (rd_en) begin
            n_checks++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL unexpected read: actual %02h expected none", rd_data);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rd_data !== e) begin
                    n_fail++;
                    $display("FAIL %s: actual %02h expected %02h", t, rd_data, e);
                end
            end
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wr_en = 1'b0;
            rd_en = 1'b0;
        end
    endtask

    task automatic wr_byte(input logic [7:0] b);
        @(negedge clk);
        rd_en = 1'b0;
        wr_en = 1'b1;
        wr_data = b;
    endtask

    task automatic wr_word(input logic [15:0] w);
        wr_byte(w[15:8]);
        wr_byte(w[7:0]);
        model = oc_add(model, w);
    endtask

    task automatic rd_byte(input logic [7:0] e, input string t);
        @(negedge clk);
        wr_en = 1'b0;
        exp_q.push_back(e);
        tag_q.push_back(t);
        rd_en = 1'b1;
    endtask

    task automatic rd_word(input string t);
        rd_byte(model[15:8], {t, " hi"});
        rd_byte(model[7:0], {t, " lo"});
        model = '0;
        idle(1);
    endtask

    task automatic do_reset();
        @(negedge clk);
        wr_en = 1'b0;
        rd_en = 1'b0;
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        model = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        idle(2);
        rst_n = 1'b1;
        // R1: reset state reads zero
        rd_word("R1 reset");
        // R2 / R5: byte order for write and read
        wr_word(16'h1234);
        idle(1);
        rd_word("R2 R5 order");
        // R6: second read cleared the sum
        rd_word("R6 cleared");
        // R3: back-to-back pairs, no stall
        wr_word(16'h0001);
        wr_word(16'hF203);
        wr_word(16'hF4F5);
        wr_word(16'hF6F7);
        idle(1);
        rd_word("R3 back-to-back");
        // R4: end-around carry cases
        wr_word(16'hFFFF);
        wr_word(16'h0001);
        idle(1);
        rd_word("R4 ffff+0001");
        wr_word(16'h8000);
        wr_word(16'h8000);
        idle(1);
        rd_word("R4 8000+8000");
        wr_word(16'hFFFF);
        wr_word(16'hFFFF);
        idle(1);
        rd_word("R4 ffff+ffff");
        // R7: low byte comes from the snapshot taken at the first read
        wr_word(16'h1111);
        idle(1);
        rd_byte(8'h11, "R7 snap hi");
        wr_word(16'h2222);
        idle(1);
        rd_byte(8'h11, "R7 snap lo");
        model = '0;
        idle(1);
        rd_word("R7 cleared after");
        // R8: a lone first byte adds nothing
        wr_byte(8'hAB);
        idle(3);
        rd_byte(8'h00, "R8 lone byte hi");
        rd_byte(8'h00, "R8 lone byte lo");
        idle(1);
        do_reset();
        wr_word(16'h0102);
        idle(1);
        rd_word("R8 reset drops partial");
        // R9: two reads give a clean start
        wr_word(16'h5A5A);
        idle(1);
        rd_byte(8'h5A, "R9 flush hi");
        rd_byte(8'h5A, "R9 flush lo");
        model = '0;
        wr_word(16'h0F0F);
        idle(1);
        rd_word("R9 fresh sum");
        idle(3);
        if (exp_q.size() != 0) begin
            n_checks++;
            n_fail++;
            $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
        end
        report();
    end
endmodule